// File: doc/BRIEF.md
# Three-Phase PWM Capture/Compare Unit

This block generates three complementary PWM pairs for a motor bridge from a 16-bit free-running timer. It also produces one extra PWM signal from a separate 10-bit timer, and it can capture timestamps on three input pins. Each 16-bit channel is either a compare channel or a capture channel. As a compare channel it drives a high-side output and a low-side output. The two outputs never overlap, because a programmable dead time separates one switching off from the other switching on. As a capture channel it records the timer count when its pin shows a selected edge. The 10-bit compare output appears on its own pin, and it can also gate all six channel outputs.

Neither timer counter is writable. Each timer restarts from its offset register, counts up to its period register, and then reloads the offset. Period and compare values written while a timer runs wait in shadow registers. They become active only when the count wraps, or at any time while the timer is stopped.

A trap input, active low, is handled by a two-state machine. In state `TS_RUN` the outputs follow the PWM logic. Transition `trip` (trap input low) enters `TS_HOLD`, where every output shows its programmed passive level. Transition `release` (software clear written while the trap input is high) returns to `TS_RUN`. The passive levels are also forced combinationally while the trap input is low, so the outputs reach them in the same cycle.

Top module: `pwm3_capcmp`

Register map (address on `bus_addr`, reads are combinational):
- 0 control: [1:0] prescale select (divide by 1, 2, 4, 8), [2] run 16-bit timer, [3] run 10-bit timer, [6:4] capture mode for channels 0..2, [7] modulation enable
- 1 16-bit period shadow, 2 16-bit offset
- 3 10-bit period shadow, 4 10-bit offset, 5 10-bit compare shadow
- 6, 7, 8 channel 0..2 compare shadow / capture value
- 9 dead time [7:0]
- 10 edge select, two bits per channel at [2i+1:2i]: bit 0 = rising, bit 1 = falling
- 11 passive levels: [2:0] high-side outputs, [5:3] low-side outputs, [6] 10-bit PWM
- 12 trap: reading bit 0 gives 1 in `TS_HOLD`; writing 1 to bit 0 requests release

## Requirements
- R1: After reset all registers read 0, the trap flag reads 0, `pwm_hi` is 000, `pwm_lo` is 111 and `pwm10` is 0.
- R2: A running timer advances once every 2^psel clocks (psel in control[1:0]). It goes from offset to period and then reloads offset, so one PWM period lasts (period-offset+1)*2^psel clocks. Both timers use psel.
- R3: With zero dead time, in compare mode `pwm_hi[i]` is 1 while the 16-bit count is below channel i's active compare value, and `pwm_lo[i]` is its inverse. A compare at or below the offset gives a constant low on `pwm_hi[i]`, and a compare above the period gives a constant high.
- R4: With dead time D, a channel output that turns on does so D prescaled ticks after its partner turns off. Over one period of N counts with H counts below compare (0<H<N), `pwm_hi` is high for max(H-D,0) clocks and `pwm_lo` for max(N-H-D,0) clocks. The two outputs of a pair are never high together.
- R5: `pwm10` is 1 while the 10-bit count is below the active 10-bit compare value and the 10-bit timer runs.
- R6: When modulation is enabled, all six channel outputs are ANDed with the 10-bit compare signal.
- R7: In capture mode, channel i stores the 16-bit count in register 6+i on an edge of `cap_in[i]` that its edge-select bits enable. The input passes through two synchronising flip-flops, so the store happens on the third clock edge after the pin changes. Edges that are not enabled leave the register unchanged.
- R8: A channel in capture mode drives 0 on both of its outputs.
- R9: While `trap_n` is low, all seven outputs equal the passive levels in the same cycle. After `trap_n` returns high, they stay at the passive levels and the trap flag reads 1 until a release is written. A release written while `trap_n` is still low has no effect.
- R10: Compare and period writes made while the timer runs take effect only when the count wraps from period to offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| cap_in | input | 3 | Capture pins, one per channel |
| trap_n | input | 1 | Trap request, active low |
| pwm_hi | output | 3 | High-side (primary) outputs |
| pwm_lo | output | 3 | Low-side (complementary) outputs |
| pwm10 | output | 1 | 10-bit compare PWM output |

## Verification
The PWM outputs are combinational from registered state. A running configuration therefore repeats exactly every period, and the bench counts high cycles over a whole-period window once it has waited several periods after restarting the timers; at that point no alignment to a particular edge is needed. A capture is due on the third clock edge after the pin changes, so the bench reads the register five cycles later. Trap forcing acts in the same cycle, so the bench samples the outputs one time step after it drives `trap_n`. The shadow-transfer check samples once after a few cycles and again after a full 65536-count wrap; the first sample shows that the old compare value is still in force, and the second shows that the new one has taken over.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    localparam logic [3:0] A_CTRL  = 4'd0;
    localparam logic [3:0] A_PER16 = 4'd1;
    localparam logic [3:0] A_OFS16 = 4'd2;
    localparam logic [3:0] A_PER10 = 4'd3;
    localparam logic [3:0] A_OFS10 = 4'd4;
    localparam logic [3:0] A_CMP10 = 4'd5;
    localparam logic [3:0] A_CHAN  = 4'd6;
    localparam logic [3:0] A_DEAD  = 4'd9;
    localparam logic [3:0] A_EDGE  = 4'd10;
    localparam logic [3:0] A_PASS  = 4'd11;
    localparam logic [3:0] A_TRAP  = 4'd12;

    typedef enum logic {TS_RUN, TS_HOLD} trap_state_t;
endpackage

// File: rtl/pwm3_timer.sv
module pwm3_timer #(
    parameter int W    = 16,
    parameter int NCMP = 1,
    parameter int PSW  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic [PSW-1:0]            psel,
    input  logic [W-1:0]              per_sh,
    input  logic [W-1:0]              ofs,
    input  logic [NCMP-1:0][W-1:0]    cmp_sh,
    output logic [W-1:0]              cnt,
    output logic [NCMP-1:0][W-1:0]    cmp_act,
    output logic                      tick
);
    localparam int PCW = (1 << PSW) - 1;

    logic [PCW-1:0] pre_q, mask;
    logic [W-1:0]   per_act;
    logic           wrap, load;

    always_comb begin
        mask = PCW'((32'd1 << psel) - 32'd1);
        tick = run && ((pre_q & mask) == mask);
        wrap = tick && (cnt == per_act);
        load = !run || wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            cnt     <= '0;
            per_act <= '0;
            cmp_act <= '0;
        end else begin
            pre_q <= run ? pre_q + 1'b1 : '0;
            if (!run)
                cnt <= ofs;
            else if (tick)
                cnt <= wrap ? ofs : cnt + 1'b1;
            if (load) begin
                per_act <= per_sh;
                cmp_act <= cmp_sh;
            end
        end
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt != per_act) |=> cnt == $past(cnt) + 1'b1);
    // R10
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(tick && cnt == per_act)) |=> $stable(cmp_act));
endmodule

// File: rtl/pwm3_chan.sv
module pwm3_chan #(
    parameter int W   = 16,
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           cap_mode,
    input  logic [W-1:0]   cnt,
    input  logic [W-1:0]   cmp,
    input  logic           tick,
    input  logic [DTW-1:0] dead,
    input  logic           pin,
    input  logic [1:0]     esel,
    output logic           out_p,
    output logic           out_n,
    output logic           cap_hit
);
    logic           raw, raw_q, settled;
    logic [DTW-1:0] dcnt;
    logic [2:0]     sync_q;

    always_comb begin
        raw     = run && !cap_mode && (cnt < cmp);
        settled = (dcnt == '0);
        out_p   = !cap_mode && raw_q && settled;
        out_n   = !cap_mode && !raw_q && settled;
        cap_hit = cap_mode && ((esel[0] && sync_q[1] && !sync_q[2]) ||
                               (esel[1] && !sync_q[1] && sync_q[2]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= 1'b0;
            dcnt   <= '0;
            sync_q <= '0;
        end else begin
            raw_q  <= raw;
            sync_q <= {sync_q[1:0], pin};
            if (raw != raw_q)
                dcnt <= dead;
            else if (tick && !settled)
                dcnt <= dcnt - 1'b1;
        end
    end

    // R4
    gap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dead != '0 && $rose(out_p)) |-> !$past(out_n));
    // R4
    gap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dead != '0 && $rose(out_n)) |-> !$past(out_p));
endmodule

// File: rtl/pwm3_capcmp.sv
module pwm3_capcmp
    import pwm3_pkg::*;
#(
    parameter int W16 = 16,
    parameter int W10 = 10,
    parameter int DTW = 8,
    parameter int NCH = 3,
    parameter int AW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [W16-1:0] bus_wdata,
    output logic [W16-1:0] bus_rdata,
    input  logic [NCH-1:0] cap_in,
    input  logic           trap_n,
    output logic [NCH-1:0] pwm_hi,
    output logic [NCH-1:0] pwm_lo,
    output logic           pwm10
);
    localparam int DW  = W16;
    localparam int NPO = 2 * NCH + 1;

    logic [7:0]               ctrl_q;
    logic [W16-1:0]           per16_q, ofs16_q, cnt16;
    logic [W10-1:0]           per10_q, ofs10_q, cmp10_q, cnt10;
    logic [NCH-1:0][W16-1:0]  chreg_q, cmp16_act;
    logic [0:0][W10-1:0]      c10_sh, c10_act;
    logic [DTW-1:0]           dead_q;
    logic [2*NCH-1:0]         esel_q;
    logic [NPO-1:0]           pass_q;
    logic [NCH-1:0]           hp, hn, hit;
    logic                     tick16, tick10, raw10, mod, safe, clr_wr;
    trap_state_t              state_q, state_d;

    assign c10_sh[0] = cmp10_q;
    assign clr_wr    = bus_we && bus_addr == A_TRAP && bus_wdata[0];

    pwm3_timer #(.W(W16), .NCMP(NCH), .PSW(2)) u_t16 (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q[2]), .psel(ctrl_q[1:0]),
        .per_sh(per16_q), .ofs(ofs16_q), .cmp_sh(chreg_q),
        .cnt(cnt16), .cmp_act(cmp16_act), .tick(tick16));

    pwm3_timer #(.W(W10), .NCMP(1), .PSW(2)) u_t10 (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q[3]), .psel(ctrl_q[1:0]),
        .per_sh(per10_q), .ofs(ofs10_q), .cmp_sh(c10_sh),
        .cnt(cnt10), .cmp_act(c10_act), .tick(tick10));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm3_chan #(.W(W16), .DTW(DTW)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(ctrl_q[2]), .cap_mode(ctrl_q[4+i]),
            .cnt(cnt16), .cmp(cmp16_act[i]), .tick(tick16), .dead(dead_q),
            .pin(cap_in[i]), .esel(esel_q[2*i +: 2]),
            .out_p(hp[i]), .out_n(hn[i]), .cap_hit(hit[i]));

        // R7
        capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && !(bus_we && bus_addr == AW'(A_CHAN + i)))
            |=> chreg_q[i] == $past(cnt16));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            per16_q <= '0;
            ofs16_q <= '0;
            per10_q <= '0;
            ofs10_q <= '0;
            cmp10_q <= '0;
            chreg_q <= '0;
            dead_q  <= '0;
            esel_q  <= '0;
            pass_q  <= '0;
        end else begin
            for (int i = 0; i < NCH; i++)
                if (hit[i]) chreg_q[i] <= cnt16;
            if (bus_we) begin
                unique case (bus_addr)
                    A_CTRL:  ctrl_q  <= bus_wdata[7:0];
                    A_PER16: per16_q <= bus_wdata;
                    A_OFS16: ofs16_q <= bus_wdata;
                    A_PER10: per10_q <= bus_wdata[W10-1:0];
                    A_OFS10: ofs10_q <= bus_wdata[W10-1:0];
                    A_CMP10: cmp10_q <= bus_wdata[W10-1:0];
                    A_DEAD:  dead_q  <= bus_wdata[DTW-1:0];
                    A_EDGE:  esel_q  <= bus_wdata[2*NCH-1:0];
                    A_PASS:  pass_q  <= bus_wdata[NPO-1:0];
                    default: begin
                        for (int i = 0; i < NCH; i++)
                            if (bus_addr == AW'(A_CHAN + i)) chreg_q[i] <= bus_wdata;
                    end
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata = DW'(ctrl_q);
            A_PER16: bus_rdata = per16_q;
            A_OFS16: bus_rdata = ofs16_q;
            A_PER10: bus_rdata = DW'(per10_q);
            A_OFS10: bus_rdata = DW'(ofs10_q);
            A_CMP10: bus_rdata = DW'(cmp10_q);
            A_DEAD:  bus_rdata = DW'(dead_q);
            A_EDGE:  bus_rdata = DW'(esel_q);
            A_PASS:  bus_rdata = DW'(pass_q);
            A_TRAP:  bus_rdata = DW'(state_q == TS_HOLD);
            default: begin
                for (int i = 0; i < NCH; i++)
                    if (bus_addr == AW'(A_CHAN + i)) bus_rdata = chreg_q[i];
            end
        endcase
    end

    // trap state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_RUN;
        else        state_q <= state_d;
    end

    // trap next state and outputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_RUN:  if (!trap_n)          state_d = TS_HOLD;
            TS_HOLD: if (clr_wr && trap_n) state_d = TS_RUN;
            default: state_d = TS_RUN;
        endcase
        safe  = (state_q == TS_HOLD) || !trap_n;
        raw10 = ctrl_q[3] && (cnt10 < c10_act[0]);
        mod   = !ctrl_q[7] || raw10;
        if (safe) begin
            pwm_hi = pass_q[NCH-1:0];
            pwm_lo = pass_q[2*NCH-1:NCH];
            pwm10  = pass_q[2*NCH];
        end else begin
            pwm_hi = hp & {NCH{mod}};
            pwm_lo = hn & {NCH{mod}};
            pwm10  = raw10;
        end
    end

    // R9
    trap_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_n |-> {pwm10, pwm_lo, pwm_hi} == pass_q);
    // R9
    trap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_n |=> state_q == TS_HOLD);
    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_hi & pwm_lo & ~pass_q[NCH-1:0]) == '0);
endmodule

// File: tb/pwm3_capcmp_test.sv
module pwm3_capcmp_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  cap_in = '0;
    logic        trap_n = 1'b1;
    logic [2:0]  pwm_hi, pwm_lo;
    logic        pwm10;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    int cnt_hi[3];
    int cnt_lo[3];
    int cnt10;

    always #5 clk = ~clk;

    pwm3_capcmp uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .trap_n(trap_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .pwm10(pwm10));

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic measure(input int cyc);
        for (int k = 0; k < 3; k++) begin cnt_hi[k] = 0; cnt_lo[k] = 0; end
        cnt10 = 0;
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                cnt_hi[k] += int'(pwm_hi[k]);
                cnt_lo[k] += int'(pwm_lo[k]);
            end
            cnt10 += int'(pwm10);
        end
    endtask

    function automatic int exp_h(input int cmp, input int ofs, input int n);
        if (cmp <= ofs) return 0;
        if (cmp - ofs >= n) return n;
        return cmp - ofs;
    endfunction

    function automatic int exp_hi(input int h, input int n, input int d);
        if (h == 0) return 0;
        if (h == n) return n;
        return (h > d) ? h - d : 0;
    endfunction

    function automatic int exp_lo(input int h, input int n, input int d);
        if (h == n) return 0;
        if (h == 0) return n;
        return (n - h > d) ? n - h - d : 0;
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_900_000;
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int v, h;
        int cmps[8] = '{0, 2, 3, 5, 10, 17, 18, 30};
        int dts[4]  = '{0, 1, 3, 7};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, v);  chk("R1 ctrl", v, 0);
        rd(4'd6, v);  chk("R1 ch0", v, 0);
        rd(4'd12, v); chk("R1 trap flag", v, 0);
        chk("R1 pwm_hi", int'(pwm_hi), 0);
        chk("R1 pwm_lo", int'(pwm_lo), 7);
        chk("R1 pwm10", int'(pwm10), 0);

        // R3/R4 compare and dead-time sweep, N = 16 (offset 2, period 17)
        wr(4'd1, 16'd17); wr(4'd2, 16'd2);
        foreach (cmps[ci]) foreach (dts[di]) begin
            wr(4'd0, 16'h0000);
            for (int k = 0; k < 3; k++) wr(4'(6 + k), 16'(cmps[ci] + k));
            wr(4'd9, 16'(dts[di]));
            wr(4'd0, 16'h0004);
            repeat (48) @(negedge clk);
            measure(16);
            for (int k = 0; k < 3; k++) begin
                h = exp_h(cmps[ci] + k, 2, 16);
                chk(dts[di] == 0 ? "R3 hi" : "R4 hi", cnt_hi[k], exp_hi(h, 16, dts[di]));
                chk(dts[di] == 0 ? "R3 lo" : "R4 lo", cnt_lo[k], exp_lo(h, 16, dts[di]));
            end
        end

        // R2/R5 prescaler sweep, compare 10 (H=8), 10-bit: offset 0, period 7, compare 3
        wr(4'd9, 16'd0); wr(4'd3, 16'd7); wr(4'd4, 16'd0); wr(4'd5, 16'd3);
        for (int p = 0; p < 4; p++) begin
            wr(4'd0, 16'h0000);
            for (int k = 0; k < 3; k++) wr(4'(6 + k), 16'd10);
            wr(4'd0, 16'(12 + p));
            repeat (48 << p) @(negedge clk);
            measure(16 << p);
            chk("R2 hi", cnt_hi[0], 8 << p);
            chk("R2 lo", cnt_lo[2], 8 << p);
            chk("R5 pwm10", cnt10, 6 << p);
        end

        // R6 modulation: 10-bit compare 0 blanks, compare above period passes
        wr(4'd0, 16'h0000); wr(4'd5, 16'd0); wr(4'd0, 16'h008C);
        repeat (48) @(negedge clk);
        measure(16);
        chk("R6 blank hi", cnt_hi[1], 0);
        chk("R6 blank lo", cnt_lo[1], 0);
        wr(4'd0, 16'h0000); wr(4'd5, 16'd1023); wr(4'd0, 16'h008C);
        repeat (48) @(negedge clk);
        measure(16);
        chk("R6 pass hi", cnt_hi[1], 8);
        chk("R6 pass lo", cnt_lo[1], 8);

        // R8 channel 1 in capture mode drives nothing
        wr(4'd0, 16'h0000); wr(4'd0, 16'h0024);
        repeat (48) @(negedge clk);
        measure(16);
        chk("R8 hi", cnt_hi[1], 0);
        chk("R8 lo", cnt_lo[1], 0);
        chk("R8 other ch", cnt_hi[0], 8);

        // R7 capture sweep with timer stopped: count equals offset
        wr(4'd0, 16'h0070);
        for (int ch = 0; ch < 3; ch++)
            for (int es = 0; es < 4; es++) begin
                wr(4'd10, 16'(es << (2 * ch)));
                wr(4'(6 + ch), 16'hAAAA);
                wr(4'd2, 16'(100 + ch * 8 + es));
                cap_in[ch] = 1'b1;
                repeat (5) @(negedge clk);
                rd(4'(6 + ch), v);
                chk("R7 rise", v, (es & 1) ? 100 + ch * 8 + es : 16'hAAAA);
                wr(4'(6 + ch), 16'hAAAA);
                wr(4'd2, 16'(200 + ch * 8 + es));
                cap_in[ch] = 1'b0;
                repeat (5) @(negedge clk);
                rd(4'(6 + ch), v);
                chk("R7 fall", v, (es & 2) ? 200 + ch * 8 + es : 16'hAAAA);
            end

        // R9 trap
        wr(4'd0, 16'h0000); wr(4'd2, 16'd2);
        for (int k = 0; k < 3; k++) wr(4'(6 + k), 16'd10);
        wr(4'd11, 16'h0059); wr(4'd0, 16'h000C);
        repeat (20) @(negedge clk);
        trap_n = 1'b0;
        #1 chk("R9 force", int'({pwm10, pwm_lo, pwm_hi}), 'h59);
        repeat (3) @(negedge clk);
        wr(4'd12, 16'd1);
        trap_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(4'd12, v); chk("R9 clear while low ignored", v, 1);
        chk("R9 hold", int'({pwm10, pwm_lo, pwm_hi}), 'h59);
        wr(4'd12, 16'd1);
        rd(4'd12, v); chk("R9 release", v, 0);

        // R10 shadow transfer only at wrap
        wr(4'd0, 16'h0000); wr(4'd1, 16'hFFFF); wr(4'd2, 16'd0);
        wr(4'd6, 16'h8000); wr(4'd0, 16'h0004);
        repeat (10) @(negedge clk);
        wr(4'd6, 16'd1);
        repeat (20) @(negedge clk);
        chk("R10 old compare held", int'(pwm_hi[0]), 1);
        repeat (65536) @(negedge clk);
        chk("R10 new compare after wrap", int'(pwm_hi[0]), 0);

        finish_run();
    end
endmodule